// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs external bus cycles for a 16-bit embedded controller. An internal requester hands it an address, data, byte enables, a direction and an internal-access flag. It then steps through four phases, T1 to T4, on consecutive clocks. A separate 20-bit address bus carries the full address for the whole cycle. A set of shared lines carries the address in T1 and data after that. These shared lines are registered on the falling clock edge, so the address on them appears half a clock after it appears on the dedicated address bus. Read data is sampled from the shared lines at the end of T3.

The lane layout is chosen by a static width input. In 16-bit layout both byte lanes carry address and data. In 8-bit layout the upper lane carries address only, and holds address bits 15:8 for all four phases. The lower lane carries address and data.

The block also handles reset-time straps. On the last clock before reset is released it captures the shared-line value into a configuration word, together with two strap pins. One strap suppresses the address phase on the shared lines. The other makes internal reads visible on the pins. A bus-hold request parks every output in high impedance between cycles.

Top module: `mbus_ctl`

## Requirements
- R1: A request (`req_i` high while idle and not holding) starts T1 on the next clock. T2, T3 and T4 follow on consecutive clocks, and then the block returns to idle. `done_o` is high only in T4.
- R2: In T1 the shared lines carry `addr_i[15:0]` in 16-bit layout, or `addr_i[7:0]` on lane 0 (bits 7:0) in 8-bit layout. If `aden_strap_ni` was low at reset, those lanes are tri-stated in T1.
- R3: On an external write, lane 0 carries `data_i[7:0]` and lane 1 carries `data_i[15:8]` through T2 to T4. When the address phase is suppressed, a lane whose enable is low stays tri-stated (`be_i[0]` for lane 0, `be_i[1]` for lane 1). Otherwise no data is driven in T2 to T4 except as R8 states.
- R4: `addr_o` carries the 20-bit address, with `addr_oe_o` high from the start of T1 through T4. One unit after the T1 edge, `addr_oe_o` is already high while the shared lines are still undriven. Outside a cycle, `addr_oe_o` is low.
- R5: In 8-bit layout (`narrow_i`=1), lane 1 is driven with `addr_i[15:8]` through T1 to T4.
- R6: `ale_o` is high in T1 only. `rd_no` is low in T2 and T3 of external reads. `wr_no` is low in T2 and T3 of external writes. Internal cycles (`int_i`=1) assert neither strobe.
- R7: The value on `ad_i` at the T3 to T4 edge of an external read appears on `rdata_o` in T4. In 8-bit layout the upper byte is zero. Every other cycle leaves `rdata_o` unchanged.
- R8: Show-read is enabled when `sren_strap_ni` was low at reset or `show_en_i` is high. On an internal read with show-read enabled, T3 and T4 drive `data_i` on the data lanes and put `{addr_i[19:16], data_i}` on `addr_o`.
- R9: With `hold_i` high, a cycle in progress still completes. The block then enters hold and raises `hlda_o`, and all enables and strobes stay inactive. No request starts while in hold. `hlda_o` falls one clock after `hold_i` falls.
- R10: While `rst_ni` is low, every output enable is low, the strobes are inactive, and `done_o` and `hlda_o` are low.
- R11: `cfg_o` holds the `ad_i` value from the last clock before `rst_ni` rises, and `pio_lock_o` equals the inverse of the captured `aden_strap_ni`. Both stay fixed until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset; straps are captured at its release |
| narrow_i | input | 1 | 1 selects 8-bit layout, 0 selects 16-bit layout |
| show_en_i | input | 1 | Run-time show-read enable |
| aden_strap_ni | input | 1 | Address-phase strap; low suppresses the address on the shared lines |
| sren_strap_ni | input | 1 | Show-read strap; low enables show-read |
| req_i | input | 1 | Cycle request |
| we_i | input | 1 | 1 selects write, 0 selects read |
| int_i | input | 1 | Internal-memory access |
| addr_i | input | 20 | Cycle address |
| data_i | input | 16 | Write data, or internal read data for show-read |
| be_i | input | 2 | Byte-lane enables |
| done_o | output | 1 | High in T4 |
| rdata_o | output | 16 | Captured read data |
| hold_i | input | 1 | Bus-hold request |
| hlda_o | output | 1 | Bus-hold grant |
| addr_o | output | 20 | Non-multiplexed address bus |
| addr_oe_o | output | 1 | Enable for addr_o |
| ad_i | input | 16 | Shared-line input value |
| ad_o | output | 16 | Shared-line output value |
| ad_oe_o | output | 2 | Per-lane enable for the shared lines |
| ale_o | output | 1 | Address-latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| cfg_o | output | 16 | Captured reset configuration word |
| pio_lock_o | output | 1 | Status pins locked to their status function |

## Verification
Two functions can fall into the same T3 and T4 phases: the show-read echo and the byte-lane write drive with a suppressed address phase. Each also competes with the address in T1. The bench provokes every overlap with a sweep over all four strap combinations crossed with layout, show enable, direction, internal flag and all byte-enable patterns. In every phase it checks each lane's enable and value, and the address bus, against values computed from the requirements. A hold raised during T2 checks that hold and a running cycle do not overlap: the cycle must finish before the grant.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4,
    PH_HOLD = 3'd5
  } phase_e;

  function automatic logic in_cycle(input phase_e p);
    return (p == PH_T1) || (p == PH_T2) || (p == PH_T3) || (p == PH_T4);
  endfunction
endpackage

// File: rtl/mbus_strap.sv
module mbus_strap #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ad_i,
  input  logic          aden_ni,
  input  logic          sren_ni,
  output logic [DW-1:0] cfg_o,
  output logic          aden_o,
  output logic          show_o,
  output logic          lock_o
);
  logic [DW-1:0] cfg_q;
  logic          aden_q;
  logic          sren_q;

  // tracks pins while in reset; freezes at release
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q  <= ad_i;
      aden_q <= aden_ni;
      sren_q <= sren_ni;
    end
  end

  assign cfg_o  = cfg_q;
  assign aden_o = aden_q;
  assign show_o = ~sren_q;
  assign lock_o = ~aden_q;
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             int_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] be_i,
  input  logic             hold_i,
  input  logic             narrow_i,
  input  logic [DW-1:0]    ad_i,
  output phase_e           phase_o,
  output logic             we_o,
  output logic             int_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    data_o,
  output logic [LANES-1:0] be_o,
  output logic [DW-1:0]    rdata_o,
  output logic             hlda_o,
  output logic             done_o
);
  phase_e           ph_q;
  logic             we_q, int_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q, rdata_q;
  logic [LANES-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      we_q   <= 1'b0;
      int_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (hold_i) ph_q <= PH_HOLD;
          else if (req_i) begin
            ph_q   <= PH_T1;
            we_q   <= we_i;
            int_q  <= int_i;
            addr_q <= addr_i;
            data_q <= data_i;
            be_q   <= be_i;
          end
        end
        PH_T1:   ph_q <= PH_T2;
        PH_T2:   ph_q <= PH_T3;
        PH_T3:   ph_q <= PH_T4;
        PH_T4:   ph_q <= hold_i ? PH_HOLD : PH_IDLE;
        PH_HOLD: if (!hold_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // sample the pins at the close of T3 on external reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (ph_q == PH_T3 && !we_q && !int_q)
      rdata_q <= narrow_i ? {{(DW-8){1'b0}}, ad_i[7:0]} : ad_i;
  end

  assign phase_o = ph_q;
  assign we_o    = we_q;
  assign int_o   = int_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign be_o    = be_q;
  assign rdata_o = rdata_q;
  assign hlda_o  = (ph_q == PH_HOLD);
  assign done_o  = (ph_q == PH_T4);
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic             we_i,
  input  logic             int_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] be_i,
  input  logic             narrow_i,
  input  logic             aden_i,
  input  logic             show_i,
  output logic [AW-1:0]    addr_o,
  output logic             addr_oe_o,
  output logic [DW-1:0]    ad_o,
  output logic [LANES-1:0] ad_oe_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no
);
  logic act, t1, t234, t23, t34, ext, echo;
  logic [DW-1:0]    ad_d, ad_q;
  logic [LANES-1:0] oe_d, oe_q;

  assign act  = in_cycle(phase_i);
  assign t1   = (phase_i == PH_T1);
  assign t23  = (phase_i == PH_T2) || (phase_i == PH_T3);
  assign t34  = (phase_i == PH_T3) || (phase_i == PH_T4);
  assign t234 = t23 || (phase_i == PH_T4);
  assign ext  = ~int_i;
  assign echo = int_i & ~we_i & show_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       oe;
    logic [7:0] val;
    always_comb begin
      if (narrow_i && (l != 0)) begin
        oe  = act;
        val = addr_i[l*8 +: 8];
      end else begin
        oe  = (t1 & aden_i)
            | (t234 & we_i & ext & (aden_i | be_i[l]))
            | (t34 & echo);
        val = t1 ? addr_i[l*8 +: 8] : data_i[l*8 +: 8];
      end
      if (!oe) val = '0;
    end
    assign ad_d[l*8 +: 8] = val;
    assign oe_d[l]        = oe;
  end

  // half-clock lag behind addr_o
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ad_q <= '0;
      oe_q <= '0;
    end else begin
      ad_q <= ad_d;
      oe_q <= oe_d;
    end
  end

  always_comb begin
    if (!act)            addr_o = '0;
    else if (t34 && echo) addr_o = {addr_i[AW-1:DW], data_i};
    else                 addr_o = addr_i;
  end

  assign addr_oe_o = act;
  assign ad_o      = ad_q;
  assign ad_oe_o   = oe_q;
  assign ale_o     = t1;
  assign rd_no     = ~(t23 & ext & ~we_i);
  assign wr_no     = ~(t23 & ext & we_i);
endmodule

// File: rtl/mbus_ctl.sv
module mbus_ctl
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             narrow_i,
  input  logic             show_en_i,
  input  logic             aden_strap_ni,
  input  logic             sren_strap_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             int_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] be_i,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  input  logic             hold_i,
  output logic             hlda_o,
  output logic [AW-1:0]    addr_o,
  output logic             addr_oe_o,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic [LANES-1:0] ad_oe_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic [DW-1:0]    cfg_o,
  output logic             pio_lock_o
);
  phase_e           phase;
  logic             cyc_we, cyc_int, aden, strap_show;
  logic [AW-1:0]    cyc_addr;
  logic [DW-1:0]    cyc_data;
  logic [LANES-1:0] cyc_be;

  mbus_strap #(.DW(DW)) u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ad_i    (ad_i),
    .aden_ni (aden_strap_ni),
    .sren_ni (sren_strap_ni),
    .cfg_o   (cfg_o),
    .aden_o  (aden),
    .show_o  (strap_show),
    .lock_o  (pio_lock_o)
  );

  mbus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .int_i    (int_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .be_i     (be_i),
    .hold_i   (hold_i),
    .narrow_i (narrow_i),
    .ad_i     (ad_i),
    .phase_o  (phase),
    .we_o     (cyc_we),
    .int_o    (cyc_int),
    .addr_o   (cyc_addr),
    .data_o   (cyc_data),
    .be_o     (cyc_be),
    .rdata_o  (rdata_o),
    .hlda_o   (hlda_o),
    .done_o   (done_o)
  );

  mbus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .we_i      (cyc_we),
    .int_i     (cyc_int),
    .addr_i    (cyc_addr),
    .data_i    (cyc_data),
    .be_i      (cyc_be),
    .narrow_i  (narrow_i),
    .aden_i    (aden),
    .show_i    (strap_show | show_en_i),
    .addr_o    (addr_o),
    .addr_oe_o (addr_oe_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .rd_no     (rd_no),
    .wr_no     (wr_no)
  );
endmodule

// File: rtl/mbus_ctl_chk.sv
module mbus_ctl_chk #(
  parameter int DW = 16,
  localparam int LANES = DW / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ale_o,
  input logic             done_o,
  input logic             addr_oe_o,
  input logic [LANES-1:0] ad_oe_o,
  input logic             hlda_o,
  input logic             rd_no,
  input logic             wr_no,
  input logic [DW-1:0]    cfg_o
);
  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;
  end

  p_four_phase_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ##3 done_o);
  p_ale_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  p_addr_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> ale_o);
  p_hold_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!addr_oe_o && !ale_o && rd_no && wr_no && !done_o));
  p_ad_in_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o != '0) |-> addr_oe_o);
  p_cfg_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q |-> $stable(cfg_o));
endmodule

bind mbus_ctl mbus_ctl_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ale_o     (ale_o),
  .done_o    (done_o),
  .addr_oe_o (addr_oe_o),
  .ad_oe_o   (ad_oe_o),
  .hlda_o    (hlda_o),
  .rd_no     (rd_no),
  .wr_no     (wr_no),
  .cfg_o     (cfg_o)
);

// File: tb/sim_mbus_ctl.sv
`timescale 1ns/100ps
module sim_mbus_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow = 1'b0, show_en = 1'b0, aden_n = 1'b1, sren_n = 1'b1;
  logic        req = 1'b0, we = 1'b0, intl = 1'b0, hold = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] data = '0, ad_in = '0;
  logic [1:0]  be = '0;
  logic        done, hlda, addr_oe, ale, rd_n, wr_n, lock;
  logic [15:0] rdata, ad_out, cfg;
  logic [19:0] addr_out;
  logic [1:0]  ad_oe;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] exp_rd = '0;

  always #2.5 clk = ~clk;

  mbus_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .narrow_i(narrow), .show_en_i(show_en),
    .aden_strap_ni(aden_n), .sren_strap_ni(sren_n),
    .req_i(req), .we_i(we), .int_i(intl), .addr_i(addr), .data_i(data), .be_i(be),
    .done_o(done), .rdata_o(rdata), .hold_i(hold), .hlda_o(hlda),
    .addr_o(addr_out), .addr_oe_o(addr_oe), .ad_i(ad_in), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n),
    .cfg_o(cfg), .pio_lock_o(lock)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #3.5;
  endtask

  task automatic chk_quiet(input string tag);
    chk(ad_oe == 2'b00 && !addr_oe && !ale && rd_n && wr_n && !done, tag,
        {ad_oe, addr_oe, ale, rd_n, wr_n, done}, 7'b0000110);
  endtask

  task automatic do_reset(input logic an, input logic sn, input logic [15:0] pat);
    rst_n = 1'b0; aden_n = an; sren_n = sn; ad_in = pat; req = 0; hold = 0;
    step(); step(); step();
    chk_quiet("R10 reset outputs");
    chk(!hlda, "R10 hlda", hlda, 0);
    rst_n = 1'b1;
    step();
    chk(cfg == pat, "R11 cfg", cfg, pat);
    chk(lock == ~an, "R11 lock", lock, ~an);
    ad_in = ~pat; aden_n = ~an; sren_n = ~sn;
  endtask

  task automatic run_cycle(input bit w, input bit it, input logic [19:0] a,
                           input logic [15:0] d, input logic [1:0] b, input logic [15:0] rv,
                           input bit aden, input bit strap_show);
    bit showx;
    logic [19:0] eaddr;
    logic        eoe;
    logic [7:0]  ev;
    string       tg;
    showx = it && !w && (strap_show || show_en);
    req = 1; we = w; intl = it; addr = a; data = d; be = b; ad_in = rv;
    @(posedge clk);
    #1;
    chk(addr_oe && ad_oe == 2'b00, "R4 lead", {addr_oe, ad_oe}, 3'b100);
    #2.5;
    req = 0;
    for (int ph = 1; ph <= 4; ph++) begin
      if (ph > 1) step();
      eaddr = (ph >= 3 && showx) ? {a[19:16], d} : a;
      chk(addr_oe && addr_out == eaddr, (ph >= 3 && showx) ? "R8 addr" : "R4 addr",
          {11'h0, addr_oe, addr_out}, {12'h001, eaddr});
      for (int l = 0; l < 2; l++) begin
        if (narrow && l == 1) begin
          eoe = 1; ev = a[15:8]; tg = "R5 upper";
        end else begin
          eoe = (ph == 1 && aden) || (ph >= 2 && w && !it && (aden || b[l])) || (ph >= 3 && showx);
          ev  = !eoe ? 8'h00 : (ph == 1) ? a[l*8 +: 8] : d[l*8 +: 8];
          tg  = (ph == 1) ? "R2 lane" : (ph >= 3 && showx) ? "R8 lane" : "R3 lane";
        end
        chk(ad_oe[l] == eoe && ad_out[l*8 +: 8] == ev, tg,
            {ad_oe[l], ad_out[l*8 +: 8]}, {eoe, ev});
      end
      chk(ale == (ph == 1) &&
          rd_n == !((ph == 2 || ph == 3) && !w && !it) &&
          wr_n == !((ph == 2 || ph == 3) && w && !it), "R6 strobes",
          {ale, rd_n, wr_n},
          {ph == 1, !((ph == 2 || ph == 3) && !w && !it), !((ph == 2 || ph == 3) && w && !it)});
      chk(done == (ph == 4), "R1 done", done, ph == 4);
      if (ph == 4) begin
        if (!w && !it) exp_rd = narrow ? {8'h00, rv[7:0]} : rv;
        chk(rdata == exp_rd, "R7 rdata", rdata, exp_rd);
      end
    end
    step();
    chk_quiet("R1 back to idle");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    int idx;
    idx = 0;
    for (int c = 0; c < 4; c++) begin
      pat = 16'hA5C3 ^ (16'h1111 * c[15:0]);
      do_reset(c[0], c[1], pat);
      exp_rd = 16'h0000;
      for (int n = 0; n < 2; n++)
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 2; w++)
            for (int it = 0; it < 2; it++)
              for (int b = 0; b < 4; b++) begin
                narrow = n[0]; show_en = s[0];
                idx++;
                run_cycle(w[0], it[0], 20'h5_0000 ^ (20'h01357 * idx[19:0]),
                          16'h9C00 ^ (16'h0123 * idx[15:0]), b[1:0],
                          16'h3E81 ^ (16'h0707 * idx[15:0]), c[0], !c[1]);
              end
      chk(cfg == pat, "R11 cfg held", cfg, pat);
      chk(lock == !c[0], "R11 lock held", lock, !c[0]);
    end

    // hold requested while idle; request blocked until release
    narrow = 0; show_en = 0;
    hold = 1;
    step();
    chk(hlda, "R9 grant", hlda, 1);
    chk_quiet("R9 parked");
    req = 1; we = 1; intl = 0; addr = 20'hABCDE; data = 16'h1234; be = 2'b11;
    step(); step();
    chk(hlda && !ale, "R9 no start", {hlda, ale}, 2'b10);
    hold = 0;
    step();
    chk(!hlda && !ale, "R9 release", {hlda, ale}, 2'b00);
    step();
    chk(ale, "R9 start after release", ale, 1);
    req = 0;
    step(); step(); step();
    chk(done, "R1 done after hold", done, 1);
    step();
    chk_quiet("R1 idle after hold");

    // hold raised mid-cycle: cycle completes first
    req = 1; we = 1; addr = 20'h12345; data = 16'h5A5A;
    step();
    chk(ale, "R9 cycle begins", ale, 1);
    req = 0;
    step();
    hold = 1;
    step();
    chk(!wr_n && !hlda, "R9 T3 continues", {wr_n, hlda}, 2'b00);
    step();
    chk(done && !hlda, "R9 T4 completes", {done, hlda}, 2'b10);
    step();
    chk(hlda, "R9 grant after cycle", hlda, 1);
    chk_quiet("R9 parked after cycle");
    hold = 0;
    step();
    chk(!hlda, "R9 release after cycle", hlda, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule